// File: doc/BRIEF.md
# Idle Drive Polling Timer

This block reproduces the legacy drive-status polling behaviour of a disk controller while it sits idle. A free-running tick counter advances only when the controller reports idle. Its period is a parameterized count of clock cycles for one millisecond at the fastest data rate. The period doubles for each slower rate step. The first tick after a hardware or software reset starts a polling pass. That pass marks a ready-change as pending for all four logical drives and raises an interrupt request. Later ticks generate nothing until the next reset.

Software clears the pending drives one at a time with sense-interrupt acknowledges. Each acknowledge removes the lowest-numbered pending drive. The interrupt line drops for one cycle after each acknowledge and returns while drives remain pending. A configuration input can suppress the pass. If it is high when the first tick arrives, the pass is cancelled until the next reset.

Top module: `idle_poll_timer`

## Requirements
- R1: While reset is low, and on the first cycle after it, the outputs are drive_pend = 0, irq = 0 and drive_num = 0.
- R2: The tick period is P = BASE_CYC << rate_sel idle clock cycles. rate_sel 0 is 500 kbps, 1 is 250 kbps, 2 is 125 kbps and 3 is 62.5 kbps. Counting from reset release, the P-th rising edge with ctrl_idle high is the tick edge.
- R3: The first tick after reset sets drive_pend to 4'b1111 (bit n is drive n), with irq = 1 and drive_num = 0. Later ticks never set pending bits again until another reset.
- R4: If poll_off is high at the first tick after reset, no pass occurs. No pass occurs later either, even after poll_off falls, until the next reset.
- R5: drive_num gives the index of the lowest set drive_pend bit, or 0 when none is set. Each cycle with sense_ack high clears that lowest bit. A sense_ack with nothing pending changes nothing.
- R6: irq equals the OR of drive_pend, except that it is low in the cycle after any cycle with sense_ack high.
- R7: While ctrl_idle is low, the tick counter holds its value, and it resumes from that value when ctrl_idle returns high.
- R8: A synchronous sw_reset acts like the hardware reset. It clears drive_pend, re-arms the pass and restarts the count, and it takes priority over sense_ack.
- R9: When sense_ack coincides with the tick edge of an armed pass, the pass wins and all four drives are pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_reset | input | 1 | Synchronous software reset |
| ctrl_idle | input | 1 | Controller is in its idle phase |
| rate_sel | input | 2 | Data-rate select, scales the tick period |
| poll_off | input | 1 | Configuration bit that disables polling |
| sense_ack | input | 1 | Sense-interrupt acknowledge strobe |
| drive_num | output | 2 | Lowest-numbered pending drive |
| drive_pend | output | 4 | Per-drive pending ready-change bits |
| irq | output | 1 | Interrupt request |

## Verification
The pass and an acknowledge can land on the same clock edge. The bench provokes this by holding sense_ack high during exactly the P-th idle cycle after reset. It judges the result from the ports: all four pending bits must be set, irq must be low for one cycle and then rise. A second collision, software reset together with an acknowledge while drives are pending, is checked to leave nothing pending. Every timing check is swept over all four rate selections with the edge count computed from P.

// File: rtl/idle_poll_timer.sv
module idle_poll_timer #(
  parameter int BASE_CYC = 16000,
  parameter int NDRV     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sw_reset,
  input  logic                    ctrl_idle,
  input  logic [1:0]              rate_sel,
  input  logic                    poll_off,
  input  logic                    sense_ack,
  output logic [$clog2(NDRV)-1:0] drive_num,
  output logic [NDRV-1:0]         drive_pend,
  output logic                    irq
);
  localparam int DW   = $clog2(NDRV);
  localparam int MAXP = BASE_CYC << 3;
  localparam int CW   = $clog2(MAXP + 1);

  logic [CW-1:0]   cnt, period;
  logic [NDRV-1:0] low_bit;
  logic            armed, gap, tick;

  assign period  = CW'(BASE_CYC) << rate_sel;
  assign tick    = ctrl_idle && (cnt >= period - 1'b1);
  assign low_bit = drive_pend & (~drive_pend + 1'b1);
  assign irq     = (|drive_pend) & ~gap;

  always_comb begin
    drive_num = '0;
    for (int i = NDRV - 1; i >= 0; i--)
      if (drive_pend[i]) drive_num = DW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      armed      <= 1'b1;
      gap        <= 1'b0;
      drive_pend <= '0;
    end else if (sw_reset) begin
      cnt        <= '0;
      armed      <= 1'b1;
      gap        <= 1'b0;
      drive_pend <= '0;
    end else begin
      gap <= sense_ack;
      if (ctrl_idle) cnt <= tick ? '0 : cnt + 1'b1;
      if (tick && armed) begin
        armed <= 1'b0;
        if (!poll_off) drive_pend <= '1;
      end else if (sense_ack) begin
        drive_pend <= drive_pend & ~low_bit;
      end
    end
  end

  p_pass_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !sw_reset) |=> ($countones(drive_pend) <= $countones($past(drive_pend))));

  p_off_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_off && drive_pend == '0) |=> (drive_pend == '0));

  p_ack_clears_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_ack && !sw_reset && !armed && drive_pend != '0)
      |=> (int'($countones(drive_pend)) == int'($countones($past(drive_pend))) - 1));

  p_irq_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_ack && !sw_reset) |=> !irq);

  p_pause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_idle && !sw_reset) |=> $stable(cnt));

  p_swrst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (drive_pend == '0 && !irq));
endmodule

// File: tb/idle_poll_timer_tb.sv
module idle_poll_timer_tb;
  localparam int BASE = 8;

  logic       clk = 0, rst_n = 0, sw_reset = 0, ctrl_idle = 0;
  logic [1:0] rate_sel = 0;
  logic       poll_off = 0, sense_ack = 0;
  logic [1:0] drive_num;
  logic [3:0] drive_pend;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  idle_poll_timer #(.BASE_CYC(BASE), .NDRV(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .ctrl_idle(ctrl_idle),
    .rate_sel(rate_sel), .poll_off(poll_off), .sense_ack(sense_ack),
    .drive_num(drive_num), .drive_pend(drive_pend), .irq(irq));

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 0; sense_ack = 0; sw_reset = 0;
    step(1);
    rst_n = 1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    ctrl_idle = 1;
    for (int r = 0; r < 4; r++) begin
      int p;
      p = BASE << r;
      rate_sel = 2'(r);
      poll_off = 0;
      hw_reset();
      chk("R1 pend", drive_pend, 0);
      chk("R1 irq", irq, 0);
      chk("R1 num", drive_num, 0);
      step(p - 1);
      chk("R2 before tick", drive_pend, 0);
      step(1);
      chk("R2/R3 pend", drive_pend, 15);
      chk("R3 irq", irq, 1);
      chk("R3 num", drive_num, 0);
      for (int d = 0; d < 4; d++) begin
        chk("R5 num", drive_num, d);
        sense_ack = 1; step(1); sense_ack = 0;
        chk("R5 pend", drive_pend, 15 & ~((1 << (d + 1)) - 1));
        chk("R6 gap", irq, 0);
        step(1);
        chk("R6 irq", irq, d < 3 ? 1 : 0);
      end
      chk("R5 empty num", drive_num, 0);
      step(3 * p);
      chk("R3 no repeat", drive_pend, 0);

      hw_reset();
      step(3); ctrl_idle = 0; step(10); ctrl_idle = 1;
      step(p - 4);
      chk("R7 paused", drive_pend, 0);
      step(1);
      chk("R7 resumed", drive_pend, 15);

      hw_reset();
      poll_off = 1;
      step(p);
      chk("R4 off", drive_pend, 0);
      poll_off = 0;
      step(3 * p);
      chk("R4 cancelled", drive_pend, 0);
      chk("R4 irq", irq, 0);
      sw_reset = 1; step(1); sw_reset = 0;
      step(p - 1);
      chk("R8 rearm wait", drive_pend, 0);
      step(1);
      chk("R8 rearm pass", drive_pend, 15);
      sw_reset = 1; sense_ack = 1; step(1); sw_reset = 0; sense_ack = 0;
      chk("R8 priority", drive_pend, 0);
      chk("R8 irq", irq, 0);

      hw_reset();
      step(2);
      sense_ack = 1; step(1); sense_ack = 0;
      chk("R5 idle ack", drive_pend, 0);
      step(p - 4);
      sense_ack = 1; step(1); sense_ack = 0;
      chk("R9 collision pend", drive_pend, 15);
      chk("R9 collision gap", irq, 0);
      step(1);
      chk("R9 irq", irq, 1);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule